// File: doc/BRIEF.md
# Digital DLL Calibration Sequencer

This block runs the lock procedure of an all-digital delay-locked loop that de-skews a memory interface clock. It steps a coarse phase-select code until the coarse phase detector changes its verdict. It then moves a fine delay-line code, presented as a thermometer, until the fine detector settles into steady alternation. At that point it raises a locked flag. It then trims a duty-adjust code until the one-bit duty detector flips, and raises a duty-corrected flag. The stages always run in that order, and each stage repeats its step until its own completion test passes.

The block is built to survive a single upset. Each phase detector delivers three independent copies of its decision, and the sequencer acts on the majority of the three. The stage register and the three code registers are each held in three copies. Every clock the voted value is written back into all copies, so a single corrupted copy is repaired on the next edge. Adjust decisions are paced: one step is evaluated every SETTLE clocks, which gives the delay line and the detectors time to respond. After lock the fine loop keeps tracking. A long run of same-direction fine decisions, or the restart input, drops the sequencer back to its starting point.

Top module: `dll_cal_seq`

## Requirements
- R1: After reset the outputs are: coarseSel = 0, fineTherm with its lower FINE_TAPS/2 bits set (8 of 16 at default), dutyCode = 2^(DUTY_W-1) (8 at default), and locked = 0, dutyDone = 0.
- R2: While unlocked and in the coarse stage, each evaluation moves coarseSel by +1 when the voted coarse decision is 0 (early) and by -1 when it is 1 (late), wrapping modulo 2^COARSE_W. The first evaluation whose decision differs from the previous one ends the stage without moving the code, and coarseSel then holds for as long as locked stays 1.
- R3: fineTherm is always a thermometer code: its set bits form a contiguous run starting at bit 0. Each evaluation in the fine stage adds one set bit on an early (0) decision and removes one on a late (1) decision. The count saturates at 0 and at FINE_TAPS instead of wrapping.
- R4: locked rises when ALT_COUNT consecutive fine evaluations (4 at default) each reverse the previous fine decision. The evaluation that completes the run does not move the fine code.
- R5: After lock, each evaluation moves dutyCode by -1 when dutyHigh is 1 (high time above half the period) and by +1 when it is 0, saturating at 0 and at its all-ones value. The first evaluation at which dutyHigh differs from the previous one raises dutyDone without moving the code. dutyDone never stands without locked, and dutyCode does not change while unlocked.
- R6: While locked, the fine code keeps tracking the fine decisions. When RELOCK_RUN consecutive fine evaluations (8 at default) give the same decision, both flags drop and all three codes return to their R1 values.
- R7: A restart input sampled high at a clock edge returns all outputs to their R1 values at that edge, whatever the stage.
- R8: Each detector input is 3 bits, one bit per redundant copy. An inverted value on any single copy leaves the resulting codes and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| restart | input | 1 | Synchronous return to the coarse stage |
| coarseLate | input | 3 | Coarse detector verdict, three copies, 1 = late |
| fineLate | input | 3 | Fine detector verdict, three copies, 1 = late |
| dutyHigh | input | 1 | 1 = clock high time above half the period |
| coarseSel | output | COARSE_W | Coarse phase-select code |
| fineTherm | output | FINE_TAPS | Fine delay-line thermometer code |
| dutyCode | output | DUTY_W | Duty-adjust code |
| locked | output | 1 | Coarse and fine stages complete |
| dutyDone | output | 1 | Duty stage complete |

## Verification
The properties assume the detector inputs are driven by a delay line that responds to the codes. They make no assumption about detector timing, except that the codes move only at evaluation points, by one step, or to their start values on a restart or a relock. The bench models each detector as a threshold compare against a hidden target value, computed from the current outputs. The sequencer samples them only at its paced evaluation points, so the decisions it sees always reflect the settled code. Targets are picked so that every stage can reach its end condition, except in the saturation scenarios, where a target is deliberately set out of reach. Single-copy faults are injected only by inverting one of the three detector bits.

// File: rtl/dll_cal_pkg.sv
`timescale 1ns/1ps
package dll_cal_pkg;

  typedef enum logic [1:0] {
    ST_COARSE = 2'd0,
    ST_FINE   = 2'd1,
    ST_DUTY   = 2'd2,
    ST_DONE   = 2'd3
  } calState_t;

  // Control to datapath strobes, one evaluation at most per SETTLE cycles
  typedef struct packed {
    logic clear;
    logic coarseUp;
    logic coarseDn;
    logic fineUp;
    logic fineDn;
    logic dutyUp;
    logic dutyDn;
  } calStrobe_t;

endpackage

// File: rtl/dll_cal_ctrl.sv
`timescale 1ns/1ps
module dll_cal_ctrl
  import dll_cal_pkg::*;
#(
  parameter int SETTLE     = 4,
  parameter int ALT_COUNT  = 4,
  parameter int RELOCK_RUN = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       restart,
  input  logic [2:0] coarseLate,
  input  logic [2:0] fineLate,
  input  logic       dutyHigh,
  output calStrobe_t strb,
  output logic       locked,
  output logic       dutyDone
);

  localparam int TW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam int AW = $clog2(ALT_COUNT + 1);
  localparam int RW = $clog2(RELOCK_RUN + 1);
  localparam logic [TW-1:0] T_LAST   = TW'(SETTLE - 1);
  localparam logic [AW-1:0] ALT_LAST = AW'(ALT_COUNT - 1);
  localparam logic [RW-1:0] RUN_END  = RW'(RELOCK_RUN);

  // Triplicated detector samples
  logic [2:0] cSamp, fSamp;
  logic       dSamp;
  logic       cVote, fVote;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cSamp <= '0;
      fSamp <= '0;
      dSamp <= 1'b0;
    end else begin
      cSamp <= coarseLate;
      fSamp <= fineLate;
      dSamp <= dutyHigh;
    end
  end

  assign cVote = (cSamp[0] & cSamp[1]) | (cSamp[0] & cSamp[2]) | (cSamp[1] & cSamp[2]);
  assign fVote = (fSamp[0] & fSamp[1]) | (fSamp[0] & fSamp[2]) | (fSamp[1] & fSamp[2]);

  // Triplicated stage register, voted and scrubbed every clock
  logic [1:0] stQ [3];
  calState_t  stV, stN;

  assign stV = calState_t'((stQ[0] & stQ[1]) | (stQ[0] & stQ[2]) | (stQ[1] & stQ[2]));

  always_ff @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      if (!rstN) stQ[k] <= ST_COARSE;
      else       stQ[k] <= stN;
    end
  end

  // Pacing timer and decision history
  logic [TW-1:0] tQ, tN;
  logic          tick;
  logic          cPrev, cPrevN, cValid, cValidN;
  logic          fLast, fLastN, fValid, fValidN;
  logic          dPrev, dPrevN, dValid, dValidN;
  logic [AW-1:0] altQ, altN;
  logic [RW-1:0] runQ, runN, runInc, runStep;
  logic          fRev, clr;

  assign tick = (tQ == T_LAST);

  always_comb begin
    stN     = stV;
    cPrevN  = cPrev;
    cValidN = cValid;
    fLastN  = fLast;
    fValidN = fValid;
    dPrevN  = dPrev;
    dValidN = dValid;
    altN    = altQ;
    runN    = runQ;
    strb    = '0;
    clr     = 1'b0;
    fRev    = fValid && (fVote != fLast);
    runInc  = (runQ == RUN_END) ? runQ : runQ + 1'b1;
    runStep = (fValid && !fRev) ? runInc : RW'(1);

    if (restart) begin
      clr = 1'b1;
    end else if (tick) begin
      case (stV)
        ST_COARSE: begin
          if (cValid && (cVote != cPrev)) begin
            stN     = ST_FINE;
            fValidN = 1'b0;
            altN    = '0;
            runN    = '0;
          end else begin
            strb.coarseUp = !cVote;
            strb.coarseDn = cVote;
            cPrevN        = cVote;
            cValidN       = 1'b1;
          end
        end
        ST_FINE: begin
          fLastN  = fVote;
          fValidN = 1'b1;
          runN    = runStep;
          if (fRev && (altQ == ALT_LAST)) begin
            stN     = ST_DUTY;
            dValidN = 1'b0;
            altN    = '0;
          end else begin
            altN        = fRev ? altQ + 1'b1 : '0;
            strb.fineUp = !fVote;
            strb.fineDn = fVote;
          end
        end
        default: begin
          fLastN  = fVote;
          fValidN = 1'b1;
          runN    = runStep;
          if (runStep == RUN_END) begin
            clr = 1'b1;
          end else begin
            strb.fineUp = !fVote;
            strb.fineDn = fVote;
            if (stV == ST_DUTY) begin
              if (dValid && (dSamp != dPrev)) begin
                stN = ST_DONE;
              end else begin
                strb.dutyUp = !dSamp;
                strb.dutyDn = dSamp;
              end
              dPrevN  = dSamp;
              dValidN = 1'b1;
            end
          end
        end
      endcase
    end

    if (clr) begin
      stN        = ST_COARSE;
      cValidN    = 1'b0;
      fValidN    = 1'b0;
      dValidN    = 1'b0;
      altN       = '0;
      runN       = '0;
      strb       = '0;
      strb.clear = 1'b1;
    end

    tN = (clr || tick) ? '0 : tQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tQ     <= '0;
      cPrev  <= 1'b0;
      cValid <= 1'b0;
      fLast  <= 1'b0;
      fValid <= 1'b0;
      dPrev  <= 1'b0;
      dValid <= 1'b0;
      altQ   <= '0;
      runQ   <= '0;
    end else begin
      tQ     <= tN;
      cPrev  <= cPrevN;
      cValid <= cValidN;
      fLast  <= fLastN;
      fValid <= fValidN;
      dPrev  <= dPrevN;
      dValid <= dValidN;
      altQ   <= altN;
      runQ   <= runN;
    end
  end

  assign locked   = (stV == ST_DUTY) || (stV == ST_DONE);
  assign dutyDone = (stV == ST_DONE);

endmodule

// File: rtl/dll_cal_dpath.sv
`timescale 1ns/1ps
module dll_cal_dpath
  import dll_cal_pkg::*;
#(
  parameter int COARSE_W  = 3,
  parameter int FINE_TAPS = 16,
  parameter int DUTY_W    = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  calStrobe_t           strb,
  output logic [COARSE_W-1:0]  coarseSel,
  output logic [FINE_TAPS-1:0] fineTherm,
  output logic [DUTY_W-1:0]    dutyCode
);

  localparam int FAW = $clog2(FINE_TAPS + 1);
  localparam logic [FAW-1:0]    FINE_MID = FAW'(FINE_TAPS / 2);
  localparam logic [FAW-1:0]    FINE_MAX = FAW'(FINE_TAPS);
  localparam logic [DUTY_W-1:0] DUTY_MID = {1'b1, {(DUTY_W-1){1'b0}}};
  localparam logic [DUTY_W-1:0] DUTY_MAX = '1;

  // Three copies of each code register
  logic [COARSE_W-1:0] cQ [3];
  logic [FAW-1:0]      fQ [3];
  logic [DUTY_W-1:0]   dQ [3];
  logic [COARSE_W-1:0] cV, cN;
  logic [FAW-1:0]      fV, fN;
  logic [DUTY_W-1:0]   dV, dN;

  assign cV = (cQ[0] & cQ[1]) | (cQ[0] & cQ[2]) | (cQ[1] & cQ[2]);
  assign fV = (fQ[0] & fQ[1]) | (fQ[0] & fQ[2]) | (fQ[1] & fQ[2]);
  assign dV = (dQ[0] & dQ[1]) | (dQ[0] & dQ[2]) | (dQ[1] & dQ[2]);

  always_comb begin
    cN = cV;
    fN = fV;
    dN = dV;
    if (strb.clear) begin
      cN = '0;
      fN = FINE_MID;
      dN = DUTY_MID;
    end else begin
      if (strb.coarseUp)      cN = cV + 1'b1;
      else if (strb.coarseDn) cN = cV - 1'b1;
      if (strb.fineUp && (fV != FINE_MAX))  fN = fV + 1'b1;
      else if (strb.fineDn && (fV != '0))   fN = fV - 1'b1;
      if (strb.dutyUp && (dV != DUTY_MAX))  dN = dV + 1'b1;
      else if (strb.dutyDn && (dV != '0))   dN = dV - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < 3; k++) begin
      if (!rstN) begin
        cQ[k] <= '0;
        fQ[k] <= FINE_MID;
        dQ[k] <= DUTY_MID;
      end else begin
        cQ[k] <= cN;
        fQ[k] <= fN;
        dQ[k] <= dN;
      end
    end
  end

  // Accumulator to thermometer
  for (genvar i = 0; i < FINE_TAPS; i++) begin : gTherm
    assign fineTherm[i] = (fV > FAW'(i));
  end

  assign coarseSel = cV;
  assign dutyCode  = dV;

endmodule

// File: rtl/dll_cal_seq.sv
`timescale 1ns/1ps
module dll_cal_seq
  import dll_cal_pkg::*;
#(
  parameter int COARSE_W   = 3,
  parameter int FINE_TAPS  = 16,
  parameter int DUTY_W     = 4,
  parameter int SETTLE     = 4,
  parameter int ALT_COUNT  = 4,
  parameter int RELOCK_RUN = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 restart,
  input  logic [2:0]           coarseLate,
  input  logic [2:0]           fineLate,
  input  logic                 dutyHigh,
  output logic [COARSE_W-1:0]  coarseSel,
  output logic [FINE_TAPS-1:0] fineTherm,
  output logic [DUTY_W-1:0]    dutyCode,
  output logic                 locked,
  output logic                 dutyDone
);

  calStrobe_t strb;

  dll_cal_ctrl #(
    .SETTLE(SETTLE), .ALT_COUNT(ALT_COUNT), .RELOCK_RUN(RELOCK_RUN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .restart(restart),
    .coarseLate(coarseLate), .fineLate(fineLate), .dutyHigh(dutyHigh),
    .strb(strb), .locked(locked), .dutyDone(dutyDone)
  );

  dll_cal_dpath #(
    .COARSE_W(COARSE_W), .FINE_TAPS(FINE_TAPS), .DUTY_W(DUTY_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .coarseSel(coarseSel), .fineTherm(fineTherm), .dutyCode(dutyCode)
  );

endmodule

// File: rtl/dll_cal_chk.sv
`timescale 1ns/1ps
module dll_cal_chk #(
  parameter int COARSE_W  = 3,
  parameter int FINE_TAPS = 16,
  parameter int DUTY_W    = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 restart,
  input logic [COARSE_W-1:0]  coarseSel,
  input logic [FINE_TAPS-1:0] fineTherm,
  input logic [DUTY_W-1:0]    dutyCode,
  input logic                 locked,
  input logic                 dutyDone
);

  localparam logic [DUTY_W-1:0] DUTY_MID = {1'b1, {(DUTY_W-1){1'b0}}};

  int onesNow, onesPrev;
  assign onesNow = $countones(fineTherm);

  always_ff @(posedge clk) begin
    if (!rstN) onesPrev <= FINE_TAPS / 2;
    else       onesPrev <= onesNow;
  end

  assert_flag_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    dutyDone |-> locked);

  assert_duty_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && !$past(locked)) |-> $stable(dutyCode));

  assert_therm_shape_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fineTherm & (fineTherm + 1'b1)) == '0);

  assert_fine_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(restart) && !($past(locked) && !locked)) |->
      ((onesNow <= onesPrev + 1) && (onesPrev <= onesNow + 1)));

  assert_coarse_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (locked && $past(locked)) |-> $stable(coarseSel));

  assert_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (!locked && !dutyDone && coarseSel == '0));

  assert_relock_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> (coarseSel == '0 && onesNow == FINE_TAPS / 2 && dutyCode == DUTY_MID));

endmodule

bind dll_cal_seq dll_cal_chk #(
  .COARSE_W(COARSE_W), .FINE_TAPS(FINE_TAPS), .DUTY_W(DUTY_W)
) chk (
  .clk(clk), .rstN(rstN), .restart(restart), .coarseSel(coarseSel),
  .fineTherm(fineTherm), .dutyCode(dutyCode), .locked(locked), .dutyDone(dutyDone)
);

// File: tb/dll_cal_seq_test.sv
`timescale 1ns/1ps
module dll_cal_seq_test;

  localparam int COARSE_W = 3, FINE_TAPS = 16, DUTY_W = 4;

  logic clk = 1'b0, rstN = 1'b0, restart = 1'b0;
  logic [2:0] coarseLate, fineLate;
  logic dutyHigh;
  logic [COARSE_W-1:0]  coarseSel;
  logic [FINE_TAPS-1:0] fineTherm;
  logic [DUTY_W-1:0]    dutyCode;
  logic locked, dutyDone;

  // Hidden targets of the modelled delay line and detectors
  int tc = 5, tf = 11, td = 11;
  logic [2:0] cFlip = 3'b000, fFlip = 3'b000;
  int fineOnes;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dll_cal_seq uut (
    .clk(clk), .rstN(rstN), .restart(restart),
    .coarseLate(coarseLate), .fineLate(fineLate), .dutyHigh(dutyHigh),
    .coarseSel(coarseSel), .fineTherm(fineTherm), .dutyCode(dutyCode),
    .locked(locked), .dutyDone(dutyDone)
  );

  always_comb begin
    fineOnes = $countones(fineTherm);
    for (int i = 0; i < 3; i++) begin
      coarseLate[i] = (int'(coarseSel) >= tc) ^ cFlip[i];
      fineLate[i]   = (fineOnes >= tf) ^ fFlip[i];
    end
    dutyHigh = (int'(dutyCode) >= td);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
  endtask

  task automatic pulseRestart();
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
  endtask

  task automatic checkStart(input string req);
    check({req, " coarseSel"}, int'(coarseSel), 0);
    check({req, " fine ones"}, fineOnes, FINE_TAPS / 2);
    check({req, " dutyCode"}, int'(dutyCode), 8);
    check({req, " locked"}, int'(locked), 0);
    check({req, " dutyDone"}, int'(dutyDone), 0);
  endtask

  task automatic waitLock(input string req);
    int n = 0;
    while (!locked && n < 2000) begin @(negedge clk); n++; end
    check({req, " locked reached"}, int'(locked), 1);
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!dutyDone && n < 2000) begin @(negedge clk); n++; end
    check({req, " dutyDone reached"}, int'(dutyDone), 1);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkStart("R1 reset");
  endtask

  task automatic testLockUp();
    waitLock("R4");
    check("R2 coarse stops at reversal", int'(coarseSel), 5);
    check("R4 fine code at lock", fineOnes, 10);
    check("R5 dutyDone low at lock", int'(dutyDone), 0);
    waitDone("R5");
    check("R5 duty code at toggle", int'(dutyCode), 11);
    check("R5 locked held with dutyDone", int'(locked), 1);
    tf = 13;
    repeat (200) @(negedge clk);
    check("R6 fine tracks after lock", int'(fineOnes == 12 || fineOnes == 13), 1);
    check("R6 still locked while tracking", int'(locked), 1);
    check("R2 coarse held while locked", int'(coarseSel), 5);
  endtask

  task automatic testRestart();
    tc = 3; tf = 11; td = 11;
    pulseRestart();
    checkStart("R7 restart after done");
    repeat (60) @(negedge clk);
    pulseRestart();
    checkStart("R7 restart mid sequence");
    tc = 2; tf = 5; td = 5;
    pulseRestart();
    waitLock("R4 downward");
    check("R2 coarse downward target", int'(coarseSel), 2);
    check("R4 fine from above", fineOnes, 5);
    waitDone("R5 downward");
    check("R5 duty from above", int'(dutyCode), 4);
  endtask

  task automatic testVote();
    tc = 5; tf = 11; td = 11;
    cFlip = 3'b010; fFlip = 3'b100;
    pulseRestart();
    waitLock("R8");
    check("R8 coarse with one bad copy", int'(coarseSel), 5);
    check("R8 fine with one bad copy", fineOnes, 10);
    waitDone("R8");
    check("R8 duty with one bad copy", int'(dutyCode), 11);
    cFlip = 3'b000; fFlip = 3'b000;
  endtask

  task automatic testFineSat();
    tc = 3; tf = FINE_TAPS + 1;
    pulseRestart();
    repeat (200) @(negedge clk);
    check("R3 fine saturates high", fineOnes, FINE_TAPS);
    check("R3 no lock when pinned high", int'(locked), 0);
    tf = 0;
    repeat (200) @(negedge clk);
    check("R3 fine saturates low", fineOnes, 0);
    check("R3 no lock when pinned low", int'(locked), 0);
  endtask

  task automatic testDutySat();
    tc = 3; tf = 11; td = 16;
    pulseRestart();
    waitLock("R5 sat high");
    repeat (200) @(negedge clk);
    check("R5 duty saturates high", int'(dutyCode), 15);
    check("R5 no duty done when pinned high", int'(dutyDone), 0);
    td = 0;
    pulseRestart();
    waitLock("R5 sat low");
    repeat (200) @(negedge clk);
    check("R5 duty saturates low", int'(dutyCode), 0);
    check("R5 no duty done when pinned low", int'(dutyDone), 0);
  endtask

  task automatic testRelock();
    int n = 0;
    tc = 5; tf = 11; td = 11;
    pulseRestart();
    waitDone("R6 setup");
    tf = 0;
    while (locked && n < 400) begin @(negedge clk); n++; end
    checkStart("R6 relock");
    repeat (400) @(negedge clk);
    check("R6 no lock with pinned fine", int'(locked), 0);
  endtask

  initial begin
    testReset();
    testLockUp();
    testRestart();
    testVote();
    testFineSat();
    testDutySat();
    testRelock();
    report();
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

endmodule